// File: doc/BRIEF.md
# Synchronous Burst SRAM with Four-Beat Address Sequencer

This block is a clocked single-port memory of two-lane, 18-bit words with a burst address sequencer in front of it. On a rising clock edge an external word address is captured when one of two active-low address strobes is asserted. The block then walks a four-beat burst by changing only the two lowest address bits. The upper bits of the captured address stay fixed throughout. An order-select pin picks the walk: counting up with wrap, or XOR with a beat counter. An active-low advance input moves the walk forward, and holding it high gives a wait cycle.

The two strobes differ. The processor-side strobe acts only while the chip is enabled and always opens a read. The controller-side strobe opens a read or a write, depending on the write controls. With the chip disabled, it deselects the device. When both strobes are asserted, the processor-side strobe wins. Each word has two 9-bit lanes, and each lane holds 8 data bits and a parity bit. A global write stores both lanes. Otherwise a lane-write gate combined with per-lane enables picks the lanes to store. Read data is registered. An asynchronous active-low output enable controls only whether the output drivers are on.

The sequencer is a three-state machine with the states IDLE, READ and WRITE. Four transitions drive it:
- LOAD_READ: a strobe captures an address and no lane is enabled.
- LOAD_WRITE: the controller-side strobe captures an address and at least one lane is enabled.
- DESELECT: the controller-side strobe arrives while the chip is disabled, and the machine goes to IDLE.
- CONTINUE: no strobe acts while the machine is in READ or WRITE. The beat may advance, and the machine goes to WRITE if a lane is enabled and to READ otherwise.

Top module: `burst_sram`

## Requirements
- R1: With order_sel = 0, the two low address bits of beat k equal (start + k) mod 4, and the upper address bits stay fixed. Four advances from start 01 visit 01, 10, 11, 00 and then return to 01.
- R2: With order_sel = 1, the two low address bits of beat k equal start XOR k. From start 01 the beats are 01, 00, 11, 10 and then 01 again.
- R3: If advance_n is high at an edge where no strobe acts and the state is READ or WRITE, the burst address holds, so a read returns the same word again.
- R4: proc_strobe_n low with chip_en_n low captures addr_in at beat 0 and enters READ. All write controls at that edge are ignored, and the stored word is left unchanged. This holds even when ctrl_strobe_n is low at the same edge.
- R5: ctrl_strobe_n low with chip_en_n low, and proc_strobe_n high, captures addr_in at beat 0. If any lane is enabled, the enabled lanes of data_in are stored at addr_in on that edge and the state becomes WRITE. Otherwise the state becomes READ.
- R6: ctrl_strobe_n low with chip_en_n high deselects the device (IDLE). proc_strobe_n with chip_en_n high has no effect. In IDLE, advance and write controls do nothing until a strobe loads a new address.
- R7: Lane enables work as follows. all_wr_n low enables both lanes. Otherwise, lane_wr_gate_n low enables each lane i whose lane_wr_n[i] is low. Otherwise no lane is enabled. Lane 0 is data bits [8:0] (data in [7:0], parity in [8]), and lane 1 is bits [17:9] (data in [16:9], parity in [17]).
- R8: On a CONTINUE edge the beat advances first if advance_n is low. The enabled lanes are then written at the resulting address; with no lane enabled the cycle is a read of that address.
- R9: After every edge that leaves the state in READ, data_out holds the word at the burst address chosen by that edge, from that edge until the next edge. data_drive is high only in READ with out_en_n low.
- R10: out_en_n acts on data_drive without waiting for a clock edge and has no effect on the burst sequence or on data_out.
- R11: While rst_n is low and after its release, the state is IDLE and data_drive is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the sequencer |
| chip_en_n | input | 1 | Active-low chip enable |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low, read only |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, active low, read, write or deselect |
| advance_n | input | 1 | Active-low burst advance, high gives a wait cycle |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External word address |
| all_wr_n | input | 1 | Active-low write of both lanes |
| lane_wr_gate_n | input | 1 | Active-low gate for the per-lane enables |
| lane_wr_n | input | LANES | Active-low per-lane write enables |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| data_in | input | LANES*(LANE_DATA_W+1) | Write data, lanes with parity |
| data_out | output | LANES*(LANE_DATA_W+1) | Registered read data |
| data_drive | output | 1 | High when data_out is to be driven onto the bus |

## Verification
The bench builds the block with ADDR_W = 10, LANES = 2 and LANE_DATA_W = 8. This gives a 1K-word array that the bench fills completely with an address-unique pattern before any check. Every later read can then be compared with a known word, and bursts starting at all four positions inside a 4-word block are reached. The lane shape is the same as in the 16-bit-address build, and the burst logic depends only on the two low address bits. The wrap, order, wait-cycle and strobe-priority cases therefore behave as they would in the 64K-word build, which is this block at ADDR_W = 16.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_state_t;

    localparam int BEAT_W = 2;

    // low address bits of a beat: add-and-wrap or XOR walk
    function automatic logic [BEAT_W-1:0] beat_lsb(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              interleave
    );
        logic [BEAT_W-1:0] res;
        if (interleave) res = start ^ beat;
        else            res = start + beat;
        return res;
    endfunction

endpackage

// File: rtl/bsr_lane_decode.sv
module bsr_lane_decode #(
    parameter int LANES = 2
) (
    input  logic             all_wr_n,
    input  logic             lane_wr_gate_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic [LANES-1:0] lane_mask,
    output logic             wr_any
);

    // R7: global write overrides, else the gate qualifies each lane enable
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g] = !all_wr_n || (!lane_wr_gate_n && !lane_wr_n[g]);
    end

    assign wr_any = |lane_mask;

endmodule

// File: rtl/bsr_burst_ctrl.sv
module bsr_burst_ctrl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en_n,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              advance_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              wr_any,
    output cyc_state_t        state_o,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic              wr_now
);

    localparam int HI_W = ADDR_W - BEAT_W;

    cyc_state_t        state_q, state_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [BEAT_W-1:0] beat_q, beat_d;
    logic              proc_load, ctrl_load, ctrl_desel;

    assign proc_load  = !proc_strobe_n && !chip_en_n;
    assign ctrl_load  = !proc_load && !ctrl_strobe_n && !chip_en_n;
    assign ctrl_desel = !proc_load && !ctrl_strobe_n && chip_en_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CYC_IDLE;
            base_q  <= '0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            beat_q  <= beat_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        beat_d  = beat_q;
        wr_now  = 1'b0;
        if (proc_load) begin
            // LOAD_READ from the processor side
            base_d  = addr_in;
            beat_d  = '0;
            state_d = CYC_READ;
        end else if (ctrl_load) begin
            // LOAD_READ or LOAD_WRITE from the controller side
            base_d  = addr_in;
            beat_d  = '0;
            wr_now  = wr_any;
            state_d = wr_any ? CYC_WRITE : CYC_READ;
        end else if (ctrl_desel) begin
            state_d = CYC_IDLE;
        end else begin
            unique case (state_q)
                CYC_IDLE: begin
                    state_d = CYC_IDLE;
                end
                CYC_READ, CYC_WRITE: begin
                    // CONTINUE
                    if (!advance_n) beat_d = beat_q + 2'd1;
                    wr_now  = wr_any;
                    state_d = wr_any ? CYC_WRITE : CYC_READ;
                end
                default: begin
                    state_d = CYC_IDLE;
                end
            endcase
        end
    end

    assign nxt_addr = {base_d[ADDR_W-1 -: HI_W], beat_lsb(base_d[BEAT_W-1:0], beat_d, order_sel)};
    assign state_o  = state_q;

    // R4
    proc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe_n && !chip_en_n) |=> (state_q == CYC_READ && beat_q == '0));

    // R6
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_strobe_n && chip_en_n) |=> (state_q == CYC_IDLE));

    // R6
    idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CYC_IDLE && ctrl_strobe_n && (proc_strobe_n || chip_en_n))
        |=> (state_q == CYC_IDLE));

    // R3
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CYC_IDLE && ctrl_strobe_n && (proc_strobe_n || chip_en_n) && advance_n)
        |=> ($stable(beat_q) && $stable(base_q)));

    // R1
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CYC_IDLE && ctrl_strobe_n && (proc_strobe_n || chip_en_n) && !advance_n)
        |=> (beat_q == 2'($past(beat_q) + 2'd1) && $stable(base_q)));

endmodule

// File: rtl/bsr_store.sv
module bsr_store #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [LANES-1:0]        lane_mask,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_en && lane_mask[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
            rd_q <= cells[addr];
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int LANES       = 2,
    parameter int LANE_DATA_W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               chip_en_n,
    input  logic                               proc_strobe_n,
    input  logic                               ctrl_strobe_n,
    input  logic                               advance_n,
    input  logic                               order_sel,
    input  logic [ADDR_W-1:0]                  addr_in,
    input  logic                               all_wr_n,
    input  logic                               lane_wr_gate_n,
    input  logic [LANES-1:0]                   lane_wr_n,
    input  logic                               out_en_n,
    input  logic [LANES*(LANE_DATA_W+1)-1:0]   data_in,
    output logic [LANES*(LANE_DATA_W+1)-1:0]   data_out,
    output logic                               data_drive
);

    localparam int LANE_W = LANE_DATA_W + 1;

    logic [LANES-1:0]  lane_mask;
    logic              wr_any;
    logic              wr_now;
    logic [ADDR_W-1:0] nxt_addr;
    cyc_state_t        state;

    bsr_lane_decode #(.LANES(LANES)) u_decode (
        .all_wr_n       (all_wr_n),
        .lane_wr_gate_n (lane_wr_gate_n),
        .lane_wr_n      (lane_wr_n),
        .lane_mask      (lane_mask),
        .wr_any         (wr_any)
    );

    bsr_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .chip_en_n     (chip_en_n),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .advance_n     (advance_n),
        .order_sel     (order_sel),
        .addr_in       (addr_in),
        .wr_any        (wr_any),
        .state_o       (state),
        .nxt_addr      (nxt_addr),
        .wr_now        (wr_now)
    );

    bsr_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk       (clk),
        .wr_en     (wr_now),
        .lane_mask (lane_mask),
        .addr      (nxt_addr),
        .wdata     (data_in),
        .rdata     (data_out)
    );

    // R9 R10: drivers follow the read state and the asynchronous enable
    assign data_drive = (state == CYC_READ) && !out_en_n;

    // R5
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe_n && !ctrl_strobe_n && !chip_en_n && (!all_wr_n || !lane_wr_gate_n && !(&lane_wr_n)))
        |=> !data_drive);

endmodule

// File: tb/burst_sram_bench.sv
module burst_sram_bench;

    localparam int AW    = 10;
    localparam int WW    = 18;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, ce_n, proc_n, ctrl_n, adv_n, order_sel;
    logic [AW-1:0] addr_in;
    logic          all_wr_n, gate_n, oe_n;
    logic [1:0]    lane_n;
    logic [WW-1:0] din, dout;
    logic          drive;

    burst_sram #(.ADDR_W(AW)) u_burst_sram (
        .clk(clk), .rst_n(rst_n), .chip_en_n(ce_n), .proc_strobe_n(proc_n),
        .ctrl_strobe_n(ctrl_n), .advance_n(adv_n), .order_sel(order_sel),
        .addr_in(addr_in), .all_wr_n(all_wr_n), .lane_wr_gate_n(gate_n),
        .lane_wr_n(lane_n), .out_en_n(oe_n), .data_in(din),
        .data_out(dout), .data_drive(drive)
    );

    int n_chk  = 0;
    int n_fail = 0;

    typedef enum {M_IDLE, M_READ, M_WRITE} mst_t;
    logic [WW-1:0] ref_mem [DEPTH];
    mst_t          m_st = M_IDLE;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;
    logic [WW-1:0] m_rd = '0;

    function automatic logic [WW-1:0] pat(input logic [AW-1:0] a);
        logic [7:0] lo;
        lo = 8'(a * 7 + 3);
        return {a, lo};
    endfunction

    function automatic logic [AW-1:0] m_addr();
        logic [1:0] l;
        l = order_sel ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        return {m_base[AW-1:2], l};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [1:0]    m;
        logic          do_wr;
        logic [AW-1:0] a;
        m[0]  = !all_wr_n || (!gate_n && !lane_n[0]);
        m[1]  = !all_wr_n || (!gate_n && !lane_n[1]);
        do_wr = 1'b0;
        if (!proc_n && !ce_n) begin
            m_base = addr_in; m_beat = 2'd0; m_st = M_READ;
        end else if (!ctrl_n) begin
            if (!ce_n) begin
                m_base = addr_in; m_beat = 2'd0; do_wr = |m;
                m_st = do_wr ? M_WRITE : M_READ;
            end else m_st = M_IDLE;
        end else if (m_st != M_IDLE) begin
            if (!adv_n) m_beat = m_beat + 2'd1;
            do_wr = |m;
            m_st = do_wr ? M_WRITE : M_READ;
        end
        a = m_addr();
        if (do_wr) begin
            if (m[0]) ref_mem[a][8:0]  = din[8:0];
            if (m[1]) ref_mem[a][17:9] = din[17:9];
        end
        if (m_st == M_READ) m_rd = ref_mem[a];
    endtask

    // one clock: model at the edge, compare at the following falling edge
    task automatic tick(input string tag);
        @(posedge clk);
        if (rst_n) model_edge();
        else       m_st = M_IDLE;
        @(negedge clk);
        check({tag, " drive"}, 32'(drive), 32'(m_st == M_READ && !oe_n));
        if (m_st == M_READ) check({tag, " data"}, 32'(dout), 32'(m_rd));
    endtask

    task automatic quiet();
        proc_n = 1'b1; ctrl_n = 1'b1; adv_n = 1'b1; ce_n = 1'b0;
        all_wr_n = 1'b1; gate_n = 1'b1; lane_n = 2'b11; oe_n = 1'b0;
    endtask

    task automatic expect_word(input string tag, input logic [WW-1:0] w);
        check(tag, 32'(dout), 32'(w));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1553));
        quiet(); order_sel = 1'b0; addr_in = '0; din = '0; rst_n = 1'b0;
        repeat (3) tick("R11");
        @(negedge clk) rst_n = 1'b1;
        tick("R11");
        check("R11 idle after reset", 32'(drive), 32'd0);

        // R5 R7: fill every word through controller-side global writes
        for (int a = 0; a < DEPTH; a++) begin
            quiet(); ctrl_n = 1'b0; all_wr_n = 1'b0;
            addr_in = AW'(a); din = pat(AW'(a));
            tick("R5");
        end

        // R1 linear burst from ..01
        quiet(); order_sel = 1'b0; proc_n = 1'b0; addr_in = 10'h00D;
        tick("R1");
        expect_word("R1 beat0", pat(10'h00D));
        quiet(); adv_n = 1'b0;
        tick("R1"); expect_word("R1 beat1", pat(10'h00E));
        tick("R1"); expect_word("R1 beat2", pat(10'h00F));
        tick("R1"); expect_word("R1 beat3", pat(10'h00C));
        tick("R1"); expect_word("R1 wrap", pat(10'h00D));

        // R3 wait cycles
        quiet();
        tick("R3"); expect_word("R3 hold", pat(10'h00D));
        tick("R3"); expect_word("R3 hold2", pat(10'h00D));

        // R2 interleaved burst from ..01 via controller-side read
        quiet(); order_sel = 1'b1; ctrl_n = 1'b0; addr_in = 10'h11D;
        tick("R2");
        expect_word("R2 beat0", pat(10'h11D));
        quiet(); adv_n = 1'b0;
        tick("R2"); expect_word("R2 beat1", pat(10'h11C));
        tick("R2"); expect_word("R2 beat2", pat(10'h11F));
        tick("R2"); expect_word("R2 beat3", pat(10'h11E));
        tick("R2"); expect_word("R2 wrap", pat(10'h11D));

        // R4 processor strobe ignores writes, even with the controller strobe
        quiet(); order_sel = 1'b0; proc_n = 1'b0; ctrl_n = 1'b0; all_wr_n = 1'b0;
        addr_in = 10'h222; din = 18'h15555;
        tick("R4");
        check("R4 read state", 32'(drive), 32'd1);
        expect_word("R4 old word", pat(10'h222));
        quiet(); ctrl_n = 1'b0; addr_in = 10'h222;
        tick("R4"); expect_word("R4 unchanged", pat(10'h222));

        // R7 lane 0 only, then gate high means read
        quiet(); ctrl_n = 1'b0; gate_n = 1'b0; lane_n = 2'b10;
        addr_in = 10'h040; din = 18'h3FFFF;
        tick("R7");
        check("R7 write no drive", 32'(drive), 32'd0);
        quiet(); ctrl_n = 1'b0; gate_n = 1'b1; lane_n = 2'b00;
        addr_in = 10'h040; din = 18'h00000;
        tick("R7");
        expect_word("R7 lane0 written", {pat(10'h040)[17:9], 9'h1FF});
        quiet(); ctrl_n = 1'b0; gate_n = 1'b0; lane_n = 2'b01;
        addr_in = 10'h041; din = 18'h2AAAA;
        tick("R7");
        quiet(); proc_n = 1'b0; addr_in = 10'h041;
        tick("R7");
        expect_word("R7 lane1 written", {9'h155, pat(10'h041)[8:0]});

        // R8 write burst: beat 0 by strobe, then advance and write
        quiet(); ctrl_n = 1'b0; all_wr_n = 1'b0; addr_in = 10'h082; din = 18'h01111;
        tick("R8");
        quiet(); adv_n = 1'b0; all_wr_n = 1'b0; din = 18'h02222;
        tick("R8");
        quiet(); adv_n = 1'b1; all_wr_n = 1'b0; din = 18'h03333;
        tick("R8");
        quiet(); proc_n = 1'b0; addr_in = 10'h082;
        tick("R8"); expect_word("R8 beat0", 18'h01111);
        quiet(); adv_n = 1'b0;
        tick("R8"); expect_word("R8 beat1 overwritten", 18'h03333);

        // R6 deselect, then ignored processor strobe and advances
        quiet(); ctrl_n = 1'b0; ce_n = 1'b1;
        tick("R6");
        check("R6 deselected", 32'(drive), 32'd0);
        quiet(); proc_n = 1'b0; ce_n = 1'b1; addr_in = 10'h300;
        tick("R6");
        check("R6 proc ignored", 32'(drive), 32'd0);
        quiet(); adv_n = 1'b0; all_wr_n = 1'b0; din = 18'h3C3C3;
        tick("R6");
        check("R6 idle stays", 32'(drive), 32'd0);

        // R9 R10: enable high hides drivers, burst keeps moving
        quiet(); proc_n = 1'b0; addr_in = 10'h300; oe_n = 1'b1;
        tick("R10");
        check("R10 drivers off", 32'(drive), 32'd0);
        quiet(); adv_n = 1'b0; oe_n = 1'b1;
        tick("R10");
        expect_word("R10 data advanced", pat(10'h301));
        oe_n = 1'b0; #1;
        check("R10 async enable", 32'(drive), 32'd1);
        expect_word("R9 word at burst address", pat(10'h301));

        // mixed random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            proc_n    = (r[2:0] != 3'd0);
            ctrl_n    = (r[5:3] != 3'd0);
            ce_n      = (r[8:6] == 3'd0);
            adv_n     = r[9];
            order_sel = r[10];
            all_wr_n  = (r[13:11] != 3'd0);
            gate_n    = r[14];
            lane_n    = r[16:15];
            oe_n      = (r[19:17] == 3'd0);
            addr_in   = AW'($urandom);
            din       = WW'($urandom);
            tick("R8");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule